// File: doc/BRIEF.md
# Unprivileged Load/Store Access Unit

This block takes one decoded memory access (load or store, an access size with signedness, a flag that asks for an unprivileged access, the core's current privilege level, a byte address and store data) and turns it into a transaction on a single-outstanding memory request port. Stores are placed on the byte lanes picked by the low address bits, with a 4-bit write strobe. Loads come back through the same port and are extended to 32 bits.

An unprivileged access is sent to memory tagged as user level even when the core runs privileged. Memory-side permission checks then treat it exactly as if user code had issued it. From user level it is indistinguishable from a normal access. Requests that cannot be performed are rejected before they reach the bus: a signed store, an unknown size code or a misaligned halfword or word. Each of these gives a one-cycle error pulse instead.

Top module: `ldst_unpriv_unit`

## Requirements
- R1: A normal access carries the core's privilege level on `mem_priv` (1 = privileged, 0 = user).
- R2: An access with `req_unpriv` set drives `mem_priv` to 0 for the whole request, whatever `cur_priv` is; from user level it behaves like the normal access.
- R3: An unsigned byte load (size code 1) returns the byte on lane `req_addr[1:0]` (lane 0 = bits 7:0, little-endian) zero-extended to 32 bits.
- R4: A signed byte load (size code 2) returns the selected byte sign-extended to 32 bits.
- R5: Halfword loads use lane pair `req_addr[1]` (0 = bits 15:0, 1 = bits 31:16); size code 3 zero-extends and size code 4 sign-extends.
- R6: Size code 0 is a full 32-bit word: a load returns the bus word unchanged and a store writes all four lanes.
- R7: A store with size code 2 or 4, or any access with a size code of 5 to 7, pulses `err_illegal` one cycle after the request and issues no bus request; this takes precedence over an alignment fault, and the two error outputs are never high together.
- R8: A halfword with address bit 0 set, or a word with address bits [1:0] nonzero, pulses `err_align` one cycle after the request and issues no bus request.
- R9: A byte store drives `req_wdata[7:0]` onto lane `req_addr[1:0]`, a halfword store drives `req_wdata[15:0]` onto its lane pair, other lanes are zero, and `mem_wstrb` marks exactly the written lanes; loads drive a zero strobe.
- R10: `mem_req` rises one cycle after an accepted request and holds with stable address and strobe until `mem_ready`. `done` pulses for exactly one cycle, in the cycle after `mem_ready`, with the load result on `rdata`. New requests while `busy` is high are ignored.
- R11: After reset `mem_req`, `busy`, `done`, `err_align` and `err_illegal` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, sampled when not busy |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 3 | Size code: 0 word, 1 unsigned byte, 2 signed byte, 3 unsigned halfword, 4 signed halfword |
| req_unpriv | input | 1 | Perform access with user-level attribute |
| cur_priv | input | 1 | Current core privilege (1 = privileged) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data (low bits used for narrow stores) |
| busy | output | 1 | Bus access in progress |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wstrb | output | 4 | Byte-lane write strobe |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_priv | output | 1 | Access privilege attribute (1 = privileged) |
| mem_ready | input | 1 | Memory accepts/completes the request |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Extended load result |
| err_align | output | 1 | One-cycle misalignment fault pulse |
| err_illegal | output | 1 | One-cycle illegal-request pulse |

## Verification
The bench drives privileged unprivileged loads and stores. A unit that passed `cur_priv` through unchanged would tag those accesses as privileged. Bytes are loaded from every lane with the sign bit set and clear, so a wrong lane shift or a mix-up between zero and sign fill shows up as a wrong upper word. Signed stores, unknown size codes and every misalignment case are sent in; a unit that let any of them reach the bus would raise `mem_req` or the wrong error flag. A case that is both a signed store and misaligned checks that the illegal error wins. A stalled request gets a second request pushed in while busy, which exposes a unit that drops the request early, changes the address or double-pulses `done`.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
    localparam int unsigned DW     = 32;
    localparam int unsigned NLANES = DW / 8;

    typedef enum logic [2:0] {
        SZ_WORD  = 3'd0,
        SZ_UBYTE = 3'd1,
        SZ_SBYTE = 3'd2,
        SZ_UHALF = 3'd3,
        SZ_SHALF = 3'd4
    } size_e;
endpackage

// File: rtl/ldst_lane_pack.sv
module ldst_lane_pack
    import ldst_pkg::*;
(
    input  logic [2:0]        size,
    input  logic              is_store,
    input  logic [1:0]        addr_lo,
    input  logic [DW-1:0]     wdata,
    output logic [NLANES-1:0] strb,
    output logic [DW-1:0]     lane_data,
    output logic              misaligned,
    output logic              illegal
);
    always_comb begin
        strb       = '0;
        lane_data  = '0;
        misaligned = 1'b0;
        illegal    = 1'b0;
        case (size)
            SZ_WORD: begin
                misaligned = (addr_lo != 2'b00);
                strb       = '1;
                lane_data  = wdata;
            end
            SZ_UBYTE, SZ_SBYTE: begin
                illegal   = is_store && (size == SZ_SBYTE);
                strb      = 4'b0001 << addr_lo;
                lane_data = {24'b0, wdata[7:0]} << {addr_lo, 3'b000};
            end
            SZ_UHALF, SZ_SHALF: begin
                illegal    = is_store && (size == SZ_SHALF);
                misaligned = addr_lo[0];
                strb       = addr_lo[1] ? 4'b1100 : 4'b0011;
                lane_data  = {16'b0, wdata[15:0]} << {addr_lo[1], 4'b0000};
            end
            default: illegal = 1'b1;
        endcase
        if (illegal) misaligned = 1'b0;
        if (!is_store) begin
            strb      = '0;
            lane_data = '0;
        end
    end
endmodule

// File: rtl/ldst_load_extend.sv
module ldst_load_extend
    import ldst_pkg::*;
(
    input  logic [2:0]    size,
    input  logic [1:0]    addr_lo,
    input  logic [DW-1:0] bus_data,
    output logic [DW-1:0] result
);
    logic [DW-1:0] byte_shift;
    logic [DW-1:0] half_shift;
    logic [7:0]    sel_byte;
    logic [15:0]   sel_half;

    always_comb begin
        byte_shift = bus_data >> {addr_lo, 3'b000};
        half_shift = bus_data >> {addr_lo[1], 4'b0000};
        sel_byte   = byte_shift[7:0];
        sel_half   = half_shift[15:0];
        case (size)
            SZ_UBYTE: result = {24'b0, sel_byte};
            SZ_SBYTE: result = {{24{sel_byte[7]}}, sel_byte};
            SZ_UHALF: result = {16'b0, sel_half};
            SZ_SHALF: result = {{16{sel_half[15]}}, sel_half};
            default:  result = bus_data;
        endcase
    end
endmodule

// File: rtl/ldst_unpriv_unit.sv
module ldst_unpriv_unit
    import ldst_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_store,
    input  logic [2:0]        req_size,
    input  logic              req_unpriv,
    input  logic              cur_priv,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_wstrb,
    output logic [31:0]       mem_wdata,
    output logic              mem_priv,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              done,
    output logic [31:0]       rdata,
    output logic              err_align,
    output logic              err_illegal
);
    typedef struct packed {
        logic              busy;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [NLANES-1:0] strb;
        logic [DW-1:0]     wdata;
        logic              priv;
        logic [2:0]        size;
        logic              done;
        logic [DW-1:0]     rdata;
        logic              e_align;
        logic              e_illegal;
    } state_t;

    state_t st_d, st_q;

    logic [NLANES-1:0] pk_strb;
    logic [DW-1:0]     pk_data;
    logic              pk_misal;
    logic              pk_illegal;
    logic [DW-1:0]     ext_result;

    ldst_lane_pack u_pack (
        .size       (req_size),
        .is_store   (req_is_store),
        .addr_lo    (req_addr[1:0]),
        .wdata      (req_wdata),
        .strb       (pk_strb),
        .lane_data  (pk_data),
        .misaligned (pk_misal),
        .illegal    (pk_illegal)
    );

    ldst_load_extend u_ext (
        .size     (st_q.size),
        .addr_lo  (st_q.addr[1:0]),
        .bus_data (mem_rdata),
        .result   (ext_result)
    );

    always_comb begin
        st_d           = st_q;
        st_d.done      = 1'b0;
        st_d.e_align   = 1'b0;
        st_d.e_illegal = 1'b0;
        if (!st_q.busy) begin
            if (req_valid) begin
                if (pk_illegal) begin
                    st_d.e_illegal = 1'b1;
                end else if (pk_misal) begin
                    st_d.e_align = 1'b1;
                end else begin
                    st_d.busy  = 1'b1;
                    st_d.we    = req_is_store;
                    st_d.addr  = req_addr;
                    st_d.strb  = pk_strb;
                    st_d.wdata = pk_data;
                    st_d.priv  = cur_priv & ~req_unpriv;
                    st_d.size  = req_size;
                end
            end
        end else if (mem_ready) begin
            st_d.busy  = 1'b0;
            st_d.done  = 1'b1;
            st_d.rdata = st_q.we ? '0 : ext_result;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy        = st_q.busy;
    assign mem_req     = st_q.busy;
    assign mem_we      = st_q.we;
    assign mem_addr    = st_q.addr;
    assign mem_wstrb   = st_q.strb;
    assign mem_wdata   = st_q.wdata;
    assign mem_priv    = st_q.priv;
    assign done        = st_q.done;
    assign rdata       = st_q.rdata;
    assign err_align   = st_q.e_align;
    assign err_illegal = st_q.e_illegal;

    AST_UNPRIV_IS_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_unpriv) |=> (!mem_req || !mem_priv)); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_wstrb))); // R10
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_FAULT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_align || err_illegal) |-> !mem_req); // R8
    AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_align && err_illegal)); // R7
    AST_STORE_HAS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wstrb != 4'b0000)); // R9
endmodule

// File: tb/ldst_unpriv_unit_test.sv
`timescale 1ns/1ps
module ldst_unpriv_unit_test;
    localparam logic [31:0] BASE  = 32'h4000_0100;
    localparam logic [31:0] LWORD = 32'h8A7B_96C5;
    localparam logic [31:0] SWORD = 32'h1122_33F4;

    typedef struct packed {
        logic        st;
        logic [2:0]  sz;
        logic        up;
        logic        pv;
        logic [1:0]  a;
        logic [3:0]  strb;
        logic [31:0] bus_wd;
        logic [31:0] res;
        logic        epriv;
        logic [1:0]  flt;   // 0 none, 1 align, 2 illegal
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b0,3'd1,1'b0,1'b1,2'd0,4'h0,32'h0,32'h0000_00C5,1'b1,2'd0,4'd3},        // R3 R1
        '{1'b0,3'd2,1'b1,1'b1,2'd0,4'h0,32'h0,32'hFFFF_FFC5,1'b0,2'd0,4'd4},        // R4 R2
        '{1'b0,3'd2,1'b0,1'b0,2'd2,4'h0,32'h0,32'h0000_007B,1'b0,2'd0,4'd4},        // R4
        '{1'b0,3'd2,1'b0,1'b1,2'd3,4'h0,32'h0,32'hFFFF_FF8A,1'b1,2'd0,4'd4},        // R4
        '{1'b0,3'd3,1'b0,1'b1,2'd0,4'h0,32'h0,32'h0000_96C5,1'b1,2'd0,4'd5},        // R5
        '{1'b0,3'd4,1'b1,1'b0,2'd0,4'h0,32'h0,32'hFFFF_96C5,1'b0,2'd0,4'd5},        // R5
        '{1'b0,3'd4,1'b0,1'b1,2'd2,4'h0,32'h0,32'hFFFF_8A7B,1'b1,2'd0,4'd5},        // R5
        '{1'b0,3'd3,1'b1,1'b1,2'd2,4'h0,32'h0,32'h0000_8A7B,1'b0,2'd0,4'd5},        // R5 R2
        '{1'b0,3'd0,1'b0,1'b1,2'd0,4'h0,32'h0,32'h8A7B_96C5,1'b1,2'd0,4'd6},        // R6
        '{1'b1,3'd1,1'b0,1'b1,2'd1,4'h2,32'h0000_F400,32'h0,1'b1,2'd0,4'd9},        // R9
        '{1'b1,3'd3,1'b1,1'b1,2'd2,4'hC,32'h33F4_0000,32'h0,1'b0,2'd0,4'd9},        // R9 R2
        '{1'b1,3'd0,1'b0,1'b0,2'd0,4'hF,32'h1122_33F4,32'h0,1'b0,2'd0,4'd6},        // R6 R1
        '{1'b1,3'd1,1'b1,1'b0,2'd3,4'h8,32'hF400_0000,32'h0,1'b0,2'd0,4'd9},        // R9
        '{1'b1,3'd2,1'b0,1'b1,2'd0,4'h0,32'h0,32'h0,1'b0,2'd2,4'd7},                // R7
        '{1'b1,3'd4,1'b0,1'b1,2'd2,4'h0,32'h0,32'h0,1'b0,2'd2,4'd7},                // R7
        '{1'b0,3'd3,1'b0,1'b1,2'd1,4'h0,32'h0,32'h0,1'b0,2'd1,4'd8},                // R8
        '{1'b0,3'd0,1'b0,1'b1,2'd2,4'h0,32'h0,32'h0,1'b0,2'd1,4'd8},                // R8
        '{1'b1,3'd0,1'b1,1'b1,2'd3,4'h0,32'h0,32'h0,1'b0,2'd1,4'd8},                // R8
        '{1'b1,3'd4,1'b0,1'b1,2'd1,4'h0,32'h0,32'h0,1'b0,2'd2,4'd7},                // R7 wins over R8
        '{1'b0,3'd5,1'b0,1'b1,2'd0,4'h0,32'h0,32'h0,1'b0,2'd2,4'd7},                // R7
        '{1'b0,3'd0,1'b1,1'b1,2'd0,4'h0,32'h0,32'h8A7B_96C5,1'b0,2'd0,4'd2}         // R2
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_is_store = 1'b0, req_unpriv = 1'b0, cur_priv = 1'b0;
    logic [2:0]  req_size = 3'd0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        busy, mem_req, mem_we, mem_priv, done, err_align, err_illegal;
    logic [31:0] mem_addr, mem_wdata, rdata;
    logic [3:0]  mem_wstrb;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    ldst_unpriv_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_store(req_is_store),
        .req_size(req_size), .req_unpriv(req_unpriv), .cur_priv(cur_priv),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata),
        .mem_priv(mem_priv), .mem_ready(mem_ready), .mem_rdata(mem_rdata), .done(done),
        .rdata(rdata), .err_align(err_align), .err_illegal(err_illegal)
    );

    task automatic chk(input int r, input logic [31:0] act, input logic [31:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int r = int'(v.req);
        @(negedge clk);
        req_valid = 1'b1; req_is_store = v.st; req_size = v.sz; req_unpriv = v.up;
        cur_priv = v.pv; req_addr = BASE | {30'b0, v.a}; req_wdata = SWORD;
        @(negedge clk);
        req_valid = 1'b0;
        if (v.flt != 2'd0) begin
            chk(r, {31'b0, mem_req}, 32'd0, "no bus on fault");
            chk(r, {31'b0, err_align}, {31'b0, v.flt == 2'd1}, "err_align");
            chk(r, {31'b0, err_illegal}, {31'b0, v.flt == 2'd2}, "err_illegal");
        end else begin
            chk(10, {31'b0, mem_req}, 32'd1, "mem_req");
            chk(r, {31'b0, mem_we}, {31'b0, v.st}, "mem_we");
            chk(r, mem_addr, BASE | {30'b0, v.a}, "mem_addr");
            chk(r, {28'b0, mem_wstrb}, {28'b0, v.strb}, "mem_wstrb");
            if (v.st) chk(r, mem_wdata, v.bus_wd, "mem_wdata");
            chk(r, {31'b0, mem_priv}, {31'b0, v.epriv}, "mem_priv");
            mem_ready = 1'b1; mem_rdata = LWORD;
            @(negedge clk);
            mem_ready = 1'b0; mem_rdata = 32'hDEAD_BEEF;
            chk(10, {31'b0, done}, 32'd1, "done");
            chk(10, {31'b0, mem_req}, 32'd0, "mem_req drop");
            if (!v.st) chk(r, rdata, v.res, "rdata");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(11, {27'b0, mem_req, busy, done, err_align, err_illegal}, 32'd0, "reset outputs");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R10: stall, ignored second request, single done pulse
        @(negedge clk);
        req_valid = 1'b1; req_is_store = 1'b0; req_size = 3'd1; req_unpriv = 1'b0;
        cur_priv = 1'b1; req_addr = BASE | 32'd1;
        @(negedge clk);
        req_addr = 32'h7000_0000; req_size = 3'd0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(10, {31'b0, mem_req}, 32'd1, "held request");
            chk(10, mem_addr, BASE | 32'd1, "held address");
        end
        req_valid = 1'b0;
        mem_ready = 1'b1; mem_rdata = LWORD;
        @(negedge clk);
        mem_ready = 1'b0;
        chk(10, {31'b0, done}, 32'd1, "done after stall");
        chk(3, rdata, 32'h0000_0096, "byte lane 1 after stall");
        @(negedge clk);
        chk(10, {31'b0, done}, 32'd0, "done single pulse");
        chk(10, {31'b0, mem_req}, 32'd0, "second request ignored");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog: actual=%0d expected=<20000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule